// File: doc/BRIEF.md
# Sliding-Window Sign-Bit Correlation Updater

This block keeps a running correlation matrix of antipodal bit vectors, one bit per element, for a receiver that estimates channel parameters for several users at once. Each vector holds 2K bits, two per user, so the matrix is 2K by 2K. The bits come from training or tracking symbols. A window FIFO outside this block supplies, on each update, the newest vector entering the window and the oldest vector leaving it. Every matrix entry then adds the product of the two new bits and removes the product of the two old bits.

A bit of 1 stands for +1 and a bit of 0 stands for -1. A product of two such values is therefore one XNOR gate. Each entry is a saturating up/down counter that moves by +2, 0 or -2 in a single clock, so the datapath needs no multiplier. The matrix is symmetric and its diagonal cannot change, so only the strict upper triangle is stored. A combinational read port returns any entry by row and column. A clear input zeroes the whole matrix.

Top module: `sgn_corr_matrix`

## Requirements
- R1: After reset is released, every entry reads 0.
- R2: Bit value 1 encodes +1 and bit value 0 encodes -1. On a clock edge where upd_valid_i is 1 and clear_i is 0, each off-diagonal entry (i,j) changes by (new_i·new_j) − (old_i·old_j), where a product is +1 when the two bits are equal and −1 when they differ. The step is therefore +2, 0 or −2. Bit i of a vector is the value at index i.
- R3: On a clock edge where upd_valid_i and clear_i are both 0, no entry changes, whatever the values on the bit inputs.
- R4: On a clock edge where clear_i is 1, every entry becomes 0, even when upd_valid_i is 1 on the same edge.
- R5: An entry that would rise above +127 holds at +127.
- R6: An entry that would fall below −128 holds at −128.
- R7: A read with equal row and column always returns 0.
- R8: A read of (j,i) returns the same value as a read of (i,j).
- R9: rd_data_o depends only on the current read address and the stored entries, with no register in the read path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Zero all entries. Takes priority over an update |
| upd_valid_i | input | 1 | Apply one window update on this edge |
| new_bits_i | input | 2*NUM_USERS | Newest bit vector, entering the window |
| old_bits_i | input | 2*NUM_USERS | Oldest bit vector, leaving the window |
| rd_row_i | input | clog2(2*NUM_USERS) | Read row index |
| rd_col_i | input | clog2(2*NUM_USERS) | Read column index |
| rd_data_o | output | CNT_W | Signed value of the addressed entry |

## Verification
An update or clear takes effect on the clock edge that samples it. Its result appears on rd_data_o for any address during the following low phase. The read path has no register, so a new address gives its value after a short settle delay in the same cycle. The bench therefore drives every stimulus on a falling edge and lets one rising edge pass. It then sets the read address and samples 1 ns later, before the next rising edge. Each sweep reads all 2K×2K addresses against a bench-side model that applies the signed, saturating sum.

// File: rtl/sgn_corr_pkg.sv
package sgn_corr_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // flat slot of upper-triangle pair (i<j) in a w-by-w matrix
  function automatic int unsigned pair_idx(int unsigned i, int unsigned j, int unsigned w);
    return i * w - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

endpackage

// File: rtl/corr_cell.sv
module corr_cell
  import sgn_corr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             upd_i,
  input  logic             new_a_i,
  input  logic             new_b_i,
  input  logic             old_a_i,
  input  logic             old_b_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic signed [CNT_W+1:0] W_MAX   = {3'b000, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W+1:0] W_MIN   = {3'b111, {(CNT_W-1){1'b0}}};
  localparam logic signed [CNT_W+1:0] W_TWO   = {{CNT_W{1'b0}}, 2'b10};

  logic prod_new, prod_old;
  step_e step;
  logic signed [CNT_W-1:0] cnt_q, cnt_d;
  logic signed [CNT_W+1:0] wide_q, wide_sum;

  // +1 product when bits agree
  assign prod_new = ~(new_a_i ^ new_b_i);
  assign prod_old = ~(old_a_i ^ old_b_i);

  always_comb begin
    if (prod_new && !prod_old)      step = STEP_UP;
    else if (!prod_new && prod_old) step = STEP_DOWN;
    else                            step = STEP_NONE;
  end

  always_comb begin
    wide_q = $signed({{2{cnt_q[CNT_W-1]}}, cnt_q});
    unique case (step)
      STEP_UP:   wide_sum = wide_q + W_TWO;
      STEP_DOWN: wide_sum = wide_q - W_TWO;
      default:   wide_sum = wide_q;
    endcase
    if (wide_sum > W_MAX)      cnt_d = CNT_MAX;
    else if (wide_sum < W_MIN) cnt_d = CNT_MIN;
    else                       cnt_d = wide_sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (upd_i)   cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !clear_i) |=> $stable(cnt_q));

  // R4
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));

  // R5
  sat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clear_i && step == STEP_UP && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R6
  sat_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clear_i && step == STEP_DOWN && cnt_q == CNT_MIN) |=> (cnt_q == CNT_MIN));

endmodule

// File: rtl/corr_rd_sel.sv
module corr_rd_sel
  import sgn_corr_pkg::*;
#(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned IDX_W   = $clog2(VEC_W),
  parameter int unsigned N_PAIRS = VEC_W * (VEC_W - 1) / 2
) (
  input  logic [N_PAIRS*CNT_W-1:0] cnt_flat_i,
  input  logic [IDX_W-1:0]         row_i,
  input  logic [IDX_W-1:0]         col_i,
  output logic [CNT_W-1:0]         data_o
);

  int unsigned lo, hi, sel;
  logic        in_range;

  always_comb begin
    if (row_i < col_i) begin
      lo = 32'(row_i);
      hi = 32'(col_i);
    end else begin
      lo = 32'(col_i);
      hi = 32'(row_i);
    end
    in_range = (hi < VEC_W) && (lo != hi);
    sel      = in_range ? pair_idx(lo, hi, VEC_W) : 0;
    data_o   = '0;
    for (int p = 0; p < N_PAIRS; p++) begin
      if (in_range && sel == p) data_o = cnt_flat_i[p*CNT_W +: CNT_W];
    end
  end

endmodule

// File: rtl/sgn_corr_matrix.sv
module sgn_corr_matrix
  import sgn_corr_pkg::*;
#(
  parameter int unsigned NUM_USERS = 4,
  parameter int unsigned CNT_W     = 8,
  localparam int unsigned VEC_W    = 2 * NUM_USERS,
  localparam int unsigned IDX_W    = $clog2(VEC_W),
  localparam int unsigned N_PAIRS  = VEC_W * (VEC_W - 1) / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             upd_valid_i,
  input  logic [VEC_W-1:0] new_bits_i,
  input  logic [VEC_W-1:0] old_bits_i,
  input  logic [IDX_W-1:0] rd_row_i,
  input  logic [IDX_W-1:0] rd_col_i,
  output logic [CNT_W-1:0] rd_data_o
);

  logic [N_PAIRS*CNT_W-1:0] cnt_flat;

  for (genvar gi = 0; gi < VEC_W; gi++) begin : g_row
    for (genvar gj = 0; gj < VEC_W; gj++) begin : g_col
      if (gj > gi) begin : g_cell
        localparam int unsigned SLOT = pair_idx(gi, gj, VEC_W);
        corr_cell #(.CNT_W(CNT_W)) i_cell (
          .clk_i   (clk_i),
          .rst_ni  (rst_ni),
          .clear_i (clear_i),
          .upd_i   (upd_valid_i),
          .new_a_i (new_bits_i[gi]),
          .new_b_i (new_bits_i[gj]),
          .old_a_i (old_bits_i[gi]),
          .old_b_i (old_bits_i[gj]),
          .cnt_o   (cnt_flat[SLOT*CNT_W +: CNT_W])
        );
      end
    end
  end

  corr_rd_sel #(
    .VEC_W (VEC_W),
    .CNT_W (CNT_W)
  ) i_rd_sel (
    .cnt_flat_i (cnt_flat),
    .row_i      (rd_row_i),
    .col_i      (rd_col_i),
    .data_o     (rd_data_o)
  );

  // R7
  diag_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_row_i == rd_col_i) |-> (rd_data_o == '0));

endmodule

// File: tb/test_sgn_corr_matrix.sv
module test_sgn_corr_matrix;
  localparam int K = 4;
  localparam int W = 2 * K;
  localparam int IW = $clog2(W);

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, upd = 1'b0;
  logic [W-1:0] nb = '0, ob = '0;
  logic [IW-1:0] row = '0, col = '0;
  logic [7:0] rd;

  int checks = 0, errors = 0;
  int model [W][W];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  sgn_corr_matrix #(.NUM_USERS(K), .CNT_W(8)) i_sgn_corr_matrix (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .upd_valid_i(upd),
    .new_bits_i(nb), .old_bits_i(ob), .rd_row_i(row), .rd_col_i(col),
    .rd_data_o(rd));

  task automatic check(input string tag, input int r, input int c, input int exp);
    int got;
    row = IW'(r); col = IW'(c);
    #1;
    got = int'($signed(rd));
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s (%0d,%0d) got %0d exp %0d", tag, r, c, got, exp);
    end
  endtask

  task automatic sweep(input string tag);
    for (int r = 0; r < W; r++)
      for (int c = 0; c < W; c++) check(tag, r, c, model[r][c]);
  endtask

  task automatic model_clear();
    for (int r = 0; r < W; r++)
      for (int c = 0; c < W; c++) model[r][c] = 0;
  endtask

  // R2 reference: +1 when bits agree, saturate to 8-bit signed (R5, R6)
  task automatic update(input logic [W-1:0] n, input logic [W-1:0] o);
    @(negedge clk);
    nb = n; ob = o; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    for (int r = 0; r < W; r++)
      for (int c = 0; c < W; c++)
        if (r != c) begin
          int v;
          v = model[r][c] + ((n[r] == n[c]) ? 1 : -1) - ((o[r] == o[c]) ? 1 : -1);
          if (v > 127) v = 127;
          if (v < -128) v = -128;
          model[r][c] = v;
        end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1");

    for (int t = 0; t < 20; t++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      update(lfsr[7:0], lfsr[15:8]);
      sweep("R2");
    end

    // R3: bits toggle with no valid
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      nb = ~nb; ob = 8'(t * 37);
    end
    @(negedge clk);
    sweep("R3");

    // R7 / R8 / R9: symmetric, zero diagonal, combinational read
    for (int r = 0; r < W; r++)
      for (int c = 0; c < W; c++) begin
        if (r == c) check("R7", r, c, 0);
        else check("R8_R9", c, r, model[r][c]);
      end

    // R4: clear wins over a simultaneous update
    @(negedge clk);
    nb = 8'hFF; ob = 8'h55; clear = 1'b1; upd = 1'b1;
    @(negedge clk);
    clear = 1'b0; upd = 1'b0;
    model_clear();
    sweep("R4");

    // R5: mixed-parity pairs step +2; 64 updates reach +127
    for (int t = 0; t < 64; t++) update(8'hFF, 8'h55);
    check("R5", 0, 1, 127);
    update(8'hFF, 8'h55);
    check("R5", 0, 1, 127);
    check("R5", 6, 3, 127);
    sweep("R5");
    update(8'h55, 8'hFF);
    check("R5", 0, 1, 125);

    // R6: from zero, mixed-parity pairs step -2 to -128 and hold
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_clear();
    for (int t = 0; t < 65; t++) update(8'h55, 8'hFF);
    check("R6", 1, 0, -128);
    check("R6", 2, 7, -128);
    check("R6", 0, 2, 0);
    sweep("R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule